// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns host-side request addresses into link-side addresses for an outgoing bus. It holds a bank of eight programmable windows. Each window has a 64-bit compare value, a 64-bit select mask, a 64-bit replacement value, a 32-bit action word and an enable bit. For each request, the block looks for the lowest-numbered enabled window whose masked bits match the address. It replaces the masked bits with the window's replacement value and reports the window's transaction type. A global enable bit turns translation on. When that bit is clear, or when no window matches, the address leaves the block unchanged and the hit flag stays low.

Software programs the windows and the global enable through a simple 32-bit write/read register port. The register read is combinational from the address. To turn a window on, software writes all of its fields first and then writes the compare-low word with bit 0 set.

Each result appears one clock after its request. The response path is a two-state controller. ST_IDLE means no result is on the outputs. ST_RESP means a result is on the outputs this cycle. It has three transitions:
- ACCEPT: ST_IDLE to ST_RESP, when a request arrives.
- STREAM: ST_RESP to ST_RESP, when another request follows at once.
- DRAIN: ST_RESP to ST_IDLE, when no request follows.

Top module: `ob_addr_xlate`

## Requirements
- R1: After reset, every window register and the global enable read as 0. `out_valid`, `out_hit`, `out_win`, `out_type` and `out_addr` are all 0.
- R2: Window n hits a request when both of these hold:
  - its enable (bit 0 of its compare-low word) is 1;
  - `((addr ^ compare) & mask) == 0` over all 64 bits, where compare is the 64-bit compare value with bit 0 forced to 0.
  `out_hit` reports a hit only while the global enable is also 1.
- R3: On a hit, `out_addr` = `(addr & ~mask) | (replace & mask)` using the fields of the selected window.
- R4: When several windows hit, the lowest-numbered one is selected and its number appears on `out_win`. `out_win` is 0 on a miss.
- R5: `out_type` carries bits 3:0 of the selected window's action word (0x0 memory, 0x4 I/O). It is 0 on a miss.
- R6: If the global enable is 0, or no enabled window matches, `out_addr` equals the request address, and `out_hit`, `out_type` and `out_win` are 0.
- R7: The register map places window n at byte offset 0x20·n. Within a window, the word offsets are:
  - 0x00 compare low, 0x04 compare high;
  - 0x08 replace low, 0x0C replace high;
  - 0x10 mask low, 0x14 mask high;
  - 0x18 action.
  All of these read back exactly as written. Offset 0x1C, any address with bits 1:0 nonzero, and any address other than the windows and 0x100 read as 0, and writes to them change nothing.
- R8: `out_valid` is 1 exactly in the cycle after a cycle with `req_valid` high. Without a request, `out_hit`, `out_win`, `out_type` and `out_addr` hold their last values.
- R9: A register write takes effect for requests from the next cycle on. A request presented in the same cycle as a write is translated with the old contents.
- R10: The global enable is bit 6 of the control register at 0x100. The other bits of that register read as 0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address (write and read) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Host-side request address |
| out_valid | output | 1 | Result valid (one cycle after the request) |
| out_hit | output | 1 | A window translated the request |
| out_win | output | 3 | Number of the selected window |
| out_type | output | 4 | Transaction type from the selected window |
| out_addr | output | 64 | Translated or passed-through address |

## Verification
The assertions assume `req_valid` and `req_addr` are stable from one clock edge to the next. They also assume register writes and requests interact only at the edge, so a result must reflect the register contents from before a simultaneous write. The bench keeps to this by changing every input only on the falling clock edge. It puts a write and a request in the same cycle on purpose, to exercise the old-contents rule. The priority checks rely on overlapping windows. A catch-all window with a zero mask is enabled alongside narrower windows, and then disabled again so that misses are also covered.

// File: rtl/ob_xlate_pkg.sv
`timescale 1ns/1ps
package ob_xlate_pkg;
    localparam int XW         = 64;  // request address width
    localparam int RW         = 32;  // register port width
    localparam int TYPE_W     = 4;   // transaction type width
    localparam int WIN_STRIDE = 32;  // bytes of register space per window
    localparam int OFS_W      = $clog2(WIN_STRIDE);

    // word index of each field inside a window
    localparam logic [2:0] SUB_CMP_LO = 3'd0;
    localparam logic [2:0] SUB_CMP_HI = 3'd1;
    localparam logic [2:0] SUB_REP_LO = 3'd2;
    localparam logic [2:0] SUB_REP_HI = 3'd3;
    localparam logic [2:0] SUB_MSK_LO = 3'd4;
    localparam logic [2:0] SUB_MSK_HI = 3'd5;
    localparam logic [2:0] SUB_ACTION = 3'd6;

    typedef struct packed {
        logic              en;
        logic [XW-1:0]     cmp;
        logic [XW-1:0]     msk;
        logic [XW-1:0]     rep;
        logic [TYPE_W-1:0] ttype;
    } win_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_t;
endpackage

// File: rtl/ob_win_regfile.sv
`timescale 1ns/1ps
module ob_win_regfile
    import ob_xlate_pkg::*;
#(
    parameter int NUM_WIN  = 8,
    parameter int CFG_AW   = 12,
    parameter int CTRL_OFS = 'h100,
    parameter int EN_BIT   = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [RW-1:0]               cfg_wdata,
    output logic [RW-1:0]               cfg_rdata,
    output win_cfg_t [NUM_WIN-1:0]      win_cfg,
    output logic                        xlate_en
);
    localparam int WIN_SPAN = NUM_WIN * WIN_STRIDE;
    localparam int IDX_W    = CFG_AW - OFS_W;

    logic               aligned;
    logic               in_win;
    logic [2:0]         sub;
    logic               sub_ok;
    logic               ctrl_sel;
    logic [NUM_WIN-1:0] sel_vec;
    logic [RW-1:0]      rd_w [NUM_WIN];
    logic               en_q;

    assign aligned  = (cfg_addr[1:0] == 2'b00);
    assign in_win   = aligned && (32'(cfg_addr) < 32'(WIN_SPAN));
    assign sub      = cfg_addr[OFS_W-1:2];
    assign sub_ok   = (sub != 3'd7);
    assign ctrl_sel = aligned && (cfg_addr == CFG_AW'(CTRL_OFS));

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
        logic [RW-1:0] cmp_lo, cmp_hi, rep_lo, rep_hi, msk_lo, msk_hi, action;

        assign sel_vec[n] = in_win && sub_ok &&
                            (cfg_addr[CFG_AW-1:OFS_W] == IDX_W'(n));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_lo <= '0;
                cmp_hi <= '0;
                rep_lo <= '0;
                rep_hi <= '0;
                msk_lo <= '0;
                msk_hi <= '0;
                action <= '0;
            end else if (cfg_we && sel_vec[n]) begin
                unique case (sub)
                    SUB_CMP_LO: cmp_lo <= cfg_wdata;
                    SUB_CMP_HI: cmp_hi <= cfg_wdata;
                    SUB_REP_LO: rep_lo <= cfg_wdata;
                    SUB_REP_HI: rep_hi <= cfg_wdata;
                    SUB_MSK_LO: msk_lo <= cfg_wdata;
                    SUB_MSK_HI: msk_hi <= cfg_wdata;
                    SUB_ACTION: action <= cfg_wdata;
                    default:    ;
                endcase
            end
        end

        always_comb begin
            rd_w[n] = '0;
            if (sel_vec[n]) begin
                unique case (sub)
                    SUB_CMP_LO: rd_w[n] = cmp_lo;
                    SUB_CMP_HI: rd_w[n] = cmp_hi;
                    SUB_REP_LO: rd_w[n] = rep_lo;
                    SUB_REP_HI: rd_w[n] = rep_hi;
                    SUB_MSK_LO: rd_w[n] = msk_lo;
                    SUB_MSK_HI: rd_w[n] = msk_hi;
                    SUB_ACTION: rd_w[n] = action;
                    default:    rd_w[n] = '0;
                endcase
            end
        end

        // bit 0 of the compare-low word is the enable, never part of the compare
        assign win_cfg[n] = '{
            en:    cmp_lo[0],
            cmp:   {cmp_hi, cmp_lo[RW-1:1], 1'b0},
            msk:   {msk_hi, msk_lo},
            rep:   {rep_hi, rep_lo},
            ttype: action[TYPE_W-1:0]
        };
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (cfg_we && ctrl_sel) begin
            en_q <= cfg_wdata[EN_BIT];
        end
    end

    assign xlate_en = en_q;

    always_comb begin
        cfg_rdata = ctrl_sel ? (RW'(en_q) << EN_BIT) : '0;
        for (int n = 0; n < NUM_WIN; n++) begin
            cfg_rdata = cfg_rdata | rd_w[n];
        end
    end

    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (sel_vec == '0) && !ctrl_sel) |=> ($stable(win_cfg) && $stable(xlate_en)));

    // R7
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_vec, ctrl_sel}));
endmodule

// File: rtl/ob_win_match.sv
`timescale 1ns/1ps
module ob_win_match
    import ob_xlate_pkg::*;
(
    input  win_cfg_t        cfg,
    input  logic [XW-1:0]   addr,
    output logic            hit,
    output logic [XW-1:0]   xaddr
);
    logic [XW-1:0] diff;

    assign diff  = (addr ^ cfg.cmp) & cfg.msk;
    assign hit   = cfg.en && (diff == '0);
    assign xaddr = (addr & ~cfg.msk) | (cfg.rep & cfg.msk);
endmodule

// File: rtl/ob_prio_pick.sv
`timescale 1ns/1ps
module ob_prio_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N-1:0] below;

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end

    assign below = (N'(1) << idx) - N'(1);

    always_comb begin
        if (any) begin
            // R4
            lowest_first_chk: assert ((req & below) == '0);
        end
    end
endmodule

// File: rtl/ob_addr_xlate.sv
`timescale 1ns/1ps
module ob_addr_xlate
    import ob_xlate_pkg::*;
#(
    parameter int NUM_WIN  = 8,
    parameter int CFG_AW   = 12,
    parameter int CTRL_OFS = 'h100,
    parameter int EN_BIT   = 6
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_we,
    input  logic [CFG_AW-1:0]                      cfg_addr,
    input  logic [RW-1:0]                          cfg_wdata,
    output logic [RW-1:0]                          cfg_rdata,
    input  logic                                   req_valid,
    input  logic [XW-1:0]                          req_addr,
    output logic                                   out_valid,
    output logic                                   out_hit,
    output logic [((NUM_WIN > 1) ? $clog2(NUM_WIN) : 1)-1:0] out_win,
    output logic [TYPE_W-1:0]                      out_type,
    output logic [XW-1:0]                          out_addr
);
    localparam int WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    win_cfg_t [NUM_WIN-1:0]          win_cfg;
    logic                            xlate_en;
    logic [NUM_WIN-1:0]              hit_vec;
    logic [NUM_WIN-1:0][XW-1:0]      xaddr_w;
    logic                            any_hit;
    logic [WIN_IW-1:0]               pick;

    logic                            nxt_hit;
    logic [XW-1:0]                   nxt_addr;
    logic [TYPE_W-1:0]               nxt_type;
    logic [WIN_IW-1:0]               nxt_win;

    rsp_state_t                      state_q, state_d;

    ob_win_regfile #(
        .NUM_WIN  (NUM_WIN),
        .CFG_AW   (CFG_AW),
        .CTRL_OFS (CTRL_OFS),
        .EN_BIT   (EN_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win_cfg   (win_cfg),
        .xlate_en  (xlate_en)
    );

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_match
        ob_win_match u_match (
            .cfg   (win_cfg[n]),
            .addr  (req_addr),
            .hit   (hit_vec[n]),
            .xaddr (xaddr_w[n])
        );
    end

    ob_prio_pick #(
        .N  (NUM_WIN),
        .IW (WIN_IW)
    ) u_pick (
        .req (hit_vec),
        .any (any_hit),
        .idx (pick)
    );

    always_comb begin
        nxt_hit  = xlate_en && any_hit;
        nxt_addr = req_addr;
        nxt_type = '0;
        nxt_win  = '0;
        if (nxt_hit) begin
            nxt_addr = xaddr_w[pick];
            nxt_type = win_cfg[pick].ttype;
            nxt_win  = pick;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ACCEPT, STREAM, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;  // ACCEPT
            ST_RESP: if (!req_valid) state_d = ST_IDLE;  // DRAIN, else STREAM
            default: state_d = ST_IDLE;
        endcase
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_hit  <= 1'b0;
            out_addr <= '0;
            out_type <= '0;
            out_win  <= '0;
        end else if (req_valid) begin
            out_hit  <= nxt_hit;
            out_addr <= nxt_addr;
            out_type <= nxt_type;
            out_win  <= nxt_win;
        end
    end

    assign out_valid = (state_q == ST_RESP);

    // R8
    req_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R8
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_addr) && $stable(out_hit) && $stable(out_type) && $stable(out_win)));

    // R6
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlate_en) |=> (!out_hit && (out_addr == $past(req_addr))));

    // R6
    miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_addr == $past(req_addr)));

    // R5
    miss_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> ((out_type == '0) && (out_win == '0)));

    // R4
    window0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlate_en && hit_vec[0]) |=> (out_hit && (out_win == '0)));
endmodule

// File: tb/test_ob_addr_xlate.sv
`timescale 1ns/1ps
module test_ob_addr_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        out_valid;
    logic        out_hit;
    logic [2:0]  out_win;
    logic [3:0]  out_type;
    logic [63:0] out_addr;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_clo [8];
    logic [31:0] m_chi [8];
    logic [31:0] m_rlo [8];
    logic [31:0] m_rhi [8];
    logic [31:0] m_klo [8];
    logic [31:0] m_khi [8];
    logic [31:0] m_act [8];
    bit          m_en;
    bit          e_valid;
    bit          e_hit;
    logic [2:0]  e_win;
    logic [3:0]  e_type;
    logic [63:0] e_addr;

    always #5 clk = ~clk;

    ob_addr_xlate i_ob_addr_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_win   (out_win),
        .out_type  (out_type),
        .out_addr  (out_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int n = 0; n < 8; n++) begin
            m_clo[n] = 0; m_chi[n] = 0; m_rlo[n] = 0; m_rhi[n] = 0;
            m_klo[n] = 0; m_khi[n] = 0; m_act[n] = 0;
        end
        m_en = 0; e_valid = 0; e_hit = 0; e_win = 0; e_type = 0; e_addr = 0;
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int n;
        int o;
        if (a[1:0] != 2'b00) return 32'h0;
        if (a == 12'h100) return m_en ? 32'h40 : 32'h0;
        if (a >= 12'h100) return 32'h0;
        n = int'(a) / 32;
        o = (int'(a) % 32) / 4;
        case (o)
            0: return m_clo[n];
            1: return m_chi[n];
            2: return m_rlo[n];
            3: return m_rhi[n];
            4: return m_klo[n];
            5: return m_khi[n];
            6: return m_act[n];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int n;
        int o;
        if (a[1:0] != 2'b00) return;
        if (a == 12'h100) begin
            m_en = d[6];
            return;
        end
        if (a >= 12'h100) return;
        n = int'(a) / 32;
        o = (int'(a) % 32) / 4;
        case (o)
            0: m_clo[n] = d;
            1: m_chi[n] = d;
            2: m_rlo[n] = d;
            3: m_rhi[n] = d;
            4: m_klo[n] = d;
            5: m_khi[n] = d;
            6: m_act[n] = d;
            default: ;
        endcase
    endtask

    task automatic model_edge();
        logic [63:0] cmpv;
        logic [63:0] mskv;
        logic [63:0] repv;
        bit          found;
        if (!rst_n) begin
            model_clear();
            return;
        end
        if (req_valid) begin
            found  = 0;
            e_hit  = 0;
            e_win  = 0;
            e_type = 0;
            e_addr = req_addr;
            if (m_en) begin
                for (int n = 0; n < 8; n++) begin
                    cmpv = {m_chi[n], m_clo[n] & 32'hFFFF_FFFE};
                    mskv = {m_khi[n], m_klo[n]};
                    repv = {m_rhi[n], m_rlo[n]};
                    if (!found && m_clo[n][0] && (((req_addr ^ cmpv) & mskv) == 64'h0)) begin
                        found  = 1;
                        e_hit  = 1;
                        e_win  = 3'(n);
                        e_type = m_act[n][3:0];
                        e_addr = (req_addr & ~mskv) | (repv & mskv);
                    end
                end
            end
        end
        e_valid = req_valid;
        if (cfg_we) model_write(cfg_addr, cfg_wdata);
    endtask

    task automatic compare_all();
        chk(out_valid == e_valid, "R8 out_valid", 64'(out_valid), 64'(e_valid));
        chk(out_hit == e_hit, "R2 out_hit", 64'(out_hit), 64'(e_hit));
        chk(out_addr == e_addr, "R3 out_addr", out_addr, e_addr);
        chk(out_type == e_type, "R5 out_type", 64'(out_type), 64'(e_type));
        chk(out_win == e_win, "R4 out_win", 64'(out_win), 64'(e_win));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic cyc(input bit we, input logic [11:0] a, input logic [31:0] d,
                       input bit rv, input logic [63:0] ra);
        cfg_we = we; cfg_addr = a; cfg_wdata = d; req_valid = rv; req_addr = ra;
        step();
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1, a, d, 0, 64'h0);
    endtask

    task automatic rq(input logic [63:0] ra);
        cyc(0, 12'h0, 32'h0, 1, ra);
    endtask

    task automatic idle();
        cyc(0, 12'h0, 32'h0, 0, 64'h0);
    endtask

    task automatic rd_chk(input logic [11:0] a, input string tag);
        cfg_we = 0; cfg_addr = a;
        #1;
        chk(cfg_rdata == model_read(a), tag, 64'(cfg_rdata), 64'(model_read(a)));
    endtask

    task automatic prog_win(input int n, input logic [63:0] cmpv, input logic [63:0] mskv,
                            input logic [63:0] repv, input logic [31:0] act);
        logic [11:0] b;
        b = 12'(n * 32);
        wr(b + 12'h04, cmpv[63:32]);
        wr(b + 12'h08, repv[31:0]);
        wr(b + 12'h0C, repv[63:32]);
        wr(b + 12'h10, mskv[31:0]);
        wr(b + 12'h14, mskv[63:32]);
        wr(b + 12'h18, act);
        wr(b + 12'h00, cmpv[31:0] | 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R8 watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) step();
        rst_n = 1'b1;
        idle();

        // R1: reset state
        chk(out_valid == 0 && out_hit == 0 && out_addr == 0, "R1 outputs after reset",
            {out_valid, out_hit, out_addr[61:0]}, 64'h0);
        rd_chk(12'h000, "R1 read win0 cmp lo");
        rd_chk(12'h0F8, "R1 read win7 action");
        rd_chk(12'h100, "R1 read control");

        // windows 0 (memory) and 1 (I/O)
        prog_win(0, 64'h0000_0000_E800_0000, 64'h0000_0000_F800_0000,
                 64'h0000_0000_2000_0000, 32'h0020_0000);
        prog_win(1, 64'h0000_0000_F000_0000, 64'hFFFF_FFFF_F800_0000,
                 64'h0000_0002_3000_0000, 32'h0000_0004);

        // R6: global enable off passes through
        rq(64'h0000_0000_E812_3456);
        chk(out_addr == 64'h0000_0000_E812_3456 && !out_hit, "R6 disabled passthrough",
            out_addr, 64'h0000_0000_E812_3456);

        // R10: only bit 6 of control is kept
        wr(12'h100, 32'hFFFF_FFFF);
        rd_chk(12'h100, "R10 control readback");
        chk(cfg_rdata == 32'h40, "R10 control only bit 6", 64'(cfg_rdata), 64'h40);
        wr(12'h100, 32'hFFFF_FFBF);
        rd_chk(12'h100, "R10 control cleared");
        rq(64'h0000_0000_E800_0010);
        chk(!out_hit, "R10 enable clear blocks", 64'(out_hit), 64'h0);
        wr(12'h100, 32'h0000_0040);

        // R3 / R5 / R2
        rq(64'h0000_0000_E812_3456);
        chk(out_addr == 64'h0000_0000_2012_3456 && out_type == 4'h0, "R3 window0 translate",
            out_addr, 64'h0000_0000_2012_3456);
        rq(64'h0000_0000_F000_0010);
        chk(out_addr == 64'h0000_0002_3000_0010 && out_type == 4'h4, "R5 window1 I/O type",
            out_addr, 64'h0000_0002_3000_0010);
        rq(64'h0000_0001_F000_0010);
        chk(!out_hit && out_addr == 64'h0000_0001_F000_0010, "R2 upper bits mismatch",
            out_addr, 64'h0000_0001_F000_0010);
        rq(64'h0000_0000_1234_5678);
        chk(!out_hit && out_addr == 64'h0000_0000_1234_5678, "R6 miss passthrough",
            out_addr, 64'h0000_0000_1234_5678);

        // R7: register map readback
        for (int o = 0; o < 32; o += 4) rd_chk(12'(o), "R7 window0 readback");
        for (int o = 32; o < 64; o += 4) rd_chk(12'(o), "R7 window1 readback");

        // window 3: upper-half match
        prog_win(3, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_F000_0000,
                 64'h0000_00AB_5000_0000, 32'h0000_0004);
        rq(64'h0000_0001_0ABC_DEF0);
        chk(out_hit && out_win == 3'd3 && out_addr == 64'h0000_00AB_5ABC_DEF0, "R2 upper-half window",
            out_addr, 64'h0000_00AB_5ABC_DEF0);

        // window 4: bit 0 of compare-low is not compared
        prog_win(4, 64'h0000_0000_0000_1000, 64'hFFFF_FFFF_FFFF_FFFF,
                 64'h0000_0000_0000_9000, 32'h0000_0000);
        rq(64'h0000_0000_0000_1000);
        chk(out_hit && out_addr == 64'h9000, "R2 enable bit excluded hit", out_addr, 64'h9000);
        rq(64'h0000_0000_0000_1001);
        chk(!out_hit && out_addr == 64'h1001, "R2 enable bit excluded miss", out_addr, 64'h1001);

        // window 2 catch-all: priority
        prog_win(2, 64'h0, 64'h0, 64'hDEAD_BEEF_0000_0000, 32'h0000_0004);
        rq(64'h0000_0000_E800_0000);
        chk(out_win == 3'd0, "R4 window0 beats window2", 64'(out_win), 64'h0);
        rq(64'h0000_0000_1234_5678);
        chk(out_win == 3'd2 && out_addr == 64'h1234_5678, "R4 catch-all hit",
            out_addr, 64'h1234_5678);
        rq(64'h0000_0001_0ABC_DEF0);
        chk(out_win == 3'd2, "R4 window2 beats window3", 64'(out_win), 64'h2);
        wr(12'h040, 32'h0);

        // R9: write and request in the same cycle
        cyc(1, 12'h018, 32'h0000_0004, 1, 64'h0000_0000_E800_0000);
        chk(out_type == 4'h0, "R9 old action used", 64'(out_type), 64'h0);
        rq(64'h0000_0000_E800_0000);
        chk(out_type == 4'h4, "R9 new action used", 64'(out_type), 64'h4);

        // R7: unmapped and unaligned writes are ignored
        wr(12'h01C, 32'hFFFF_FFFF);
        wr(12'h104, 32'hFFFF_FFFF);
        wr(12'h002, 32'hFFFF_FFFF);
        rd_chk(12'h01C, "R7 offset 1C reads 0");
        rd_chk(12'h104, "R7 unmapped reads 0");
        rd_chk(12'h000, "R7 unaligned write ignored");
        chk(cfg_rdata == 32'hE800_0001, "R7 cmp lo unchanged", 64'(cfg_rdata), 64'hE800_0001);
        rq(64'h0000_0000_E855_0000);
        chk(out_hit && out_win == 3'd0, "R7 window0 still active", 64'(out_win), 64'h0);

        // R8: idle cycles hold outputs
        idle();
        idle();
        chk(!out_valid && out_addr == 64'h0000_0000_2055_0000, "R8 hold while idle",
            out_addr, 64'h0000_0000_2055_0000);

        // mixed traffic
        for (int k = 0; k < 200; k++) begin
            logic [31:0] lo;
            logic [63:0] a;
            int pick;
            lo = $urandom;
            pick = $urandom % 4;
            if (pick == 0) lo[31:27] = 5'b11101;
            else if (pick == 1) lo[31:27] = 5'b11110;
            a = {(($urandom % 3) == 0) ? 32'h1 : 32'h0, lo};
            if (($urandom % 5) == 0) idle();
            else rq(a);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule